// File: doc/BRIEF.md
# Secure-aware private interrupt register bank

This block is the per-processor store for the configuration and status of 32 private interrupts. Interrupts 0 to 15 are software-generated, 16 to 31 are peripheral. It keeps the group, group-modifier, enable, pending, active, priority, trigger-type and non-secure access-control state. A register bus with a non-secure attribute on every access reaches all of this state. While security is enabled, non-secure accesses are restricted to the bits of interrupts configured as non-secure group 1.

Pending state is set in three ways. Bus writes set it. A rising edge on one of the 16 peripheral lines sets it when that interrupt is edge-triggered. A software-generated interrupt request sets it after a group and access check. Level-triggered peripheral interrupts also read as pending while their line is high. Choosing which pending interrupt to signal is done downstream.

Top module: `priv_irq_bank`

## Requirements
- R1: After reset every register holds zero, every read returns zero and `rvalid_o` is low.
- R2: When `sec_dis_i`=0 and `ns_i`=1, an access sees only the bits whose group bit is 1. The other bits read as zero and ignore writes. This applies to enable, pending, active, priority and trigger-type state.
- R3: The group register (0x00) reads as zero and ignores writes for non-secure accesses while security is enabled. The group-modifier register (0x24) and the access-control register (0x28) also read as zero and ignore writes whenever security is disabled.
- R4: Set registers OR the masked write data into state and clear registers AND-NOT it: enable 0x04/0x08, pending 0x0C/0x10, active 0x14/0x18. Both addresses of a pair read back the masked state.
- R5: A pending read returns the pending latch ORed with the line level of every level-triggered peripheral interrupt. The line is sampled one cycle before use.
- R6: A 0-to-1 change on peripheral line k sets the pending bit of interrupt 16+k only if that interrupt is edge-triggered. A line held steady, or a level-triggered line, sets nothing.
- R7: Priority words sit at 0x40 to 0x5C, four 8-bit priorities per word, with the lowest interrupt in byte 0. Byte access (`byte_i`=1, data on bits 7:0) reaches a single priority at 0x40+n.
- R8: For a non-secure access to a group-1 interrupt while security is enabled, a read returns (priority<<1) truncated to 8 bits and a write stores 0x80|(value>>1). In every other case the value passes unchanged.
- R9: Word 0x1C reads zero and ignores writes. Word 0x20 shows the trigger bit of peripheral interrupt 16+k at bit 2k+1, where 1 means edge. A write there changes only the bits that the access mask allows.
- R10: A software-generated interrupt request is accepted when its group (0 = group 0, 1 = secure group 1, 2 = non-secure group 1) matches the configured group. A secure group 1 request is also accepted for an interrupt configured as group 0. The configured group is non-secure group 1 if the group bit is 1, secure group 1 if the group bit is 0 and the modifier bit is 1, and group 0 otherwise. The modifier is ignored when security is disabled.
- R11: A non-secure software-generated interrupt request while security is enabled also needs the interrupt's 2-bit access field, bits 2n+1:2n of 0x28, to be at least 1 for group 0 and at least 2 for secure group 1.
- R12: Read data appears on `rdata_o` with `rvalid_o` high exactly one cycle after the request. Unmapped addresses, and byte reads outside the priority range, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_dis_i | input | 1 | Security disabled for the whole system |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 write, 0 read |
| ns_i | input | 1 | Access is non-secure |
| byte_i | input | 1 | Byte-wide access |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| ppi_lvl_i | input | 16 | Peripheral interrupt lines 16..31 |
| sgi_req_i | input | 1 | Software-generated interrupt request |
| sgi_id_i | input | 4 | Target interrupt 0..15 |
| sgi_grp_i | input | 2 | Requested group |
| sgi_ns_i | input | 1 | Request is non-secure |

## Verification
The hardest state to reach from the ports is a software-generated request judged against a secure group 1 configuration with a partly granted access field. The stimulus first writes the modifier and access words securely. It then issues the same request with the field at 0, 1 and 2, so that each outcome shows up in the pending word. The bench also separates the pending latch from a level-triggered line. It clears pending while the line is still high, then drops the line, and it re-reads after a steady high edge-triggered line to show that nothing relatches.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_SGI = 16;
  localparam int NUM_PPI = 16;
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI;
  localparam int PRIO_W  = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 7;
  localparam int LANES   = DATA_W / PRIO_W;
  localparam int SGI_IW  = $clog2(NUM_SGI);
  localparam int WORD_IW = $clog2(NUM_IRQ / LANES);

  localparam logic [ADDR_W-1:0] A_GROUP   = 7'h00;
  localparam logic [ADDR_W-1:0] A_SETEN   = 7'h04;
  localparam logic [ADDR_W-1:0] A_CLREN   = 7'h08;
  localparam logic [ADDR_W-1:0] A_SETPEND = 7'h0C;
  localparam logic [ADDR_W-1:0] A_CLRPEND = 7'h10;
  localparam logic [ADDR_W-1:0] A_SETACT  = 7'h14;
  localparam logic [ADDR_W-1:0] A_CLRACT  = 7'h18;
  localparam logic [ADDR_W-1:0] A_CFG0    = 7'h1C;
  localparam logic [ADDR_W-1:0] A_CFG1    = 7'h20;
  localparam logic [ADDR_W-1:0] A_GMOD    = 7'h24;
  localparam logic [ADDR_W-1:0] A_NSACC   = 7'h28;

  typedef enum logic [1:0] {
    GRP_0   = 2'd0,
    GRP_1S  = 2'd1,
    GRP_1NS = 2'd2
  } irq_grp_e;
endpackage

// File: rtl/pirq_prio_bank.sv
module pirq_prio_bank
  import pirq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 byte_i,
  input  logic [WORD_IW-1:0]   word_i,
  input  logic [1:0]           off_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 ns_view_i,
  input  logic [NUM_IRQ-1:0]   mask_i,
  output logic [DATA_W-1:0]    rd_word_o,
  output logic [PRIO_W-1:0]    rd_byte_o
);
  logic [PRIO_W-1:0] prio_q [NUM_IRQ];
  logic [PRIO_W-1:0] view   [NUM_IRQ];
  logic [NUM_IRQ-1:0] hit;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    localparam int W = i / LANES;
    localparam int L = i % LANES;
    logic [PRIO_W-1:0] val;
    assign hit[i] = wr_i && mask_i[i] && (word_i == W[WORD_IW-1:0]) &&
                    (!byte_i || off_i == L[1:0]);
    assign val = byte_i ? wdata_i[PRIO_W-1:0] : wdata_i[PRIO_W*L +: PRIO_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     prio_q[i] <= '0;
      else if (hit[i]) prio_q[i] <= ns_view_i ? {1'b1, val[PRIO_W-1:1]} : val;
    end

    assign view[i] = !mask_i[i] ? '0 :
                     ns_view_i  ? {prio_q[i][PRIO_W-2:0], 1'b0} : prio_q[i];

    // R8
    nswr_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[i] && ns_view_i) |=> prio_q[i][PRIO_W-1]);
  end

  always_comb begin
    rd_word_o = '0;
    rd_byte_o = '0;
    for (int l = 0; l < LANES; l++) begin
      rd_word_o[PRIO_W*l +: PRIO_W] = view[{word_i, l[1:0]}];
    end
    rd_byte_o = view[{word_i, off_i}];
  end
endmodule

// File: rtl/pirq_edge_latch.sv
module pirq_edge_latch
  import pirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PPI-1:0] lvl_i,
  input  logic [NUM_PPI-1:0] edge_i,
  output logic [NUM_PPI-1:0] lvl_o,
  output logic [NUM_PPI-1:0] set_o
);
  logic [NUM_PPI-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign set_o = lvl_i & ~lvl_q & edge_i;
  assign lvl_o = lvl_q;

  // R6
  edge_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_o) |=> ((lvl_o & $past(set_o)) == $past(set_o)));
endmodule

// File: rtl/pirq_sgi_gate.sv
module pirq_sgi_gate
  import pirq_pkg::*;
(
  input  logic               req_i,
  input  logic [SGI_IW-1:0]  id_i,
  input  logic [1:0]         grp_i,
  input  logic               ns_i,
  input  logic               sec_en_i,
  input  logic [NUM_SGI-1:0] cfg_grp_i,
  input  logic [NUM_SGI-1:0] cfg_mod_i,
  input  logic [DATA_W-1:0]  nsacc_i,
  output logic [NUM_SGI-1:0] set_o
);
  irq_grp_e cfg, want, eff;
  logic [1:0] acc;
  logic deny;

  always_comb begin
    want = irq_grp_e'(grp_i);
    cfg  = cfg_grp_i[id_i] ? GRP_1NS : ((cfg_mod_i[id_i] && sec_en_i) ? GRP_1S : GRP_0);
    // secure group 1 request may land on a group 0 interrupt
    eff  = (want == GRP_1S && cfg == GRP_0) ? GRP_0 : want;
    acc  = nsacc_i[{id_i, 1'b0} +: 2];
    deny = ns_i && sec_en_i &&
           ((cfg == GRP_0 && acc < 2'd1) || (cfg == GRP_1S && acc < 2'd2));
    set_o = (req_i && eff == cfg && !deny) ? (NUM_SGI'(1) << id_i) : '0;
  end
endmodule

// File: rtl/priv_irq_bank.sv
module priv_irq_bank
  import pirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_dis_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ns_i,
  input  logic              byte_i,
  input  logic [6:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic [15:0]       ppi_lvl_i,
  input  logic              sgi_req_i,
  input  logic [3:0]        sgi_id_i,
  input  logic [1:0]        sgi_grp_i,
  input  logic              sgi_ns_i
);
  logic [NUM_IRQ-1:0] grp_q, en_q, pend_q, act_q;
  logic [NUM_IRQ-1:0] grp_d, en_d, pend_d, act_d;
  logic [NUM_SGI-1:0] gmod_q, gmod_d;
  logic [DATA_W-1:0]  nsacc_q, nsacc_d;
  logic [NUM_PPI-1:0] edge_q, edge_d;
  logic [DATA_W-1:0]  rdata_q, rd_val;
  logic               rvalid_q;

  logic sec_en, ns_lim, sec_acc, wr_word, rd_req, is_prio;
  logic [NUM_IRQ-1:0] mask, wm;
  logic [NUM_PPI-1:0] lvl_s, edge_set;
  logic [NUM_SGI-1:0] sgi_set;
  logic [DATA_W-1:0]  prio_word, cfg1_rd;
  logic [PRIO_W-1:0]  prio_byte;

  assign sec_en  = !sec_dis_i;
  assign ns_lim  = ns_i && sec_en;
  assign sec_acc = !ns_i && sec_en;
  assign mask    = ns_lim ? grp_q : '1;
  assign wm      = wdata_i & mask;
  assign wr_word = req_i && we_i && !byte_i;
  assign rd_req  = req_i && !we_i;
  assign is_prio = addr_i[6:5] == 2'b10;

  pirq_prio_bank u_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (req_i && we_i && is_prio),
    .byte_i    (byte_i),
    .word_i    (addr_i[4:2]),
    .off_i     (addr_i[1:0]),
    .wdata_i   (wdata_i),
    .ns_view_i (ns_lim),
    .mask_i    (mask),
    .rd_word_o (prio_word),
    .rd_byte_o (prio_byte)
  );

  pirq_edge_latch u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ppi_lvl_i),
    .edge_i (edge_q),
    .lvl_o  (lvl_s),
    .set_o  (edge_set)
  );

  pirq_sgi_gate u_sgi (
    .req_i     (sgi_req_i),
    .id_i      (sgi_id_i),
    .grp_i     (sgi_grp_i),
    .ns_i      (sgi_ns_i),
    .sec_en_i  (sec_en),
    .cfg_grp_i (grp_q[NUM_SGI-1:0]),
    .cfg_mod_i (gmod_q),
    .nsacc_i   (nsacc_q),
    .set_o     (sgi_set)
  );

  always_comb begin
    grp_d   = grp_q;
    en_d    = en_q;
    act_d   = act_q;
    gmod_d  = gmod_q;
    nsacc_d = nsacc_q;
    edge_d  = edge_q;
    pend_d  = pend_q | {edge_set, sgi_set};
    if (wr_word) begin
      unique case (addr_i)
        A_GROUP:   if (!ns_lim) grp_d = wdata_i;
        A_SETEN:   en_d   = en_q | wm;
        A_CLREN:   en_d   = en_q & ~wm;
        A_SETPEND: pend_d = pend_d | wm;
        A_CLRPEND: pend_d = pend_d & ~wm;
        A_SETACT:  act_d  = act_q | wm;
        A_CLRACT:  act_d  = act_q & ~wm;
        A_CFG1: begin
          for (int k = 0; k < NUM_PPI; k++) begin
            if (mask[NUM_SGI+k]) edge_d[k] = wdata_i[2*k+1];
          end
        end
        A_GMOD:    if (sec_acc) gmod_d  = wdata_i[NUM_SGI-1:0];
        A_NSACC:   if (sec_acc) nsacc_d = wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg1_rd = '0;
    for (int k = 0; k < NUM_PPI; k++) cfg1_rd[2*k+1] = edge_q[k] & mask[NUM_SGI+k];
  end

  always_comb begin
    rd_val = '0;
    if (byte_i) begin
      if (is_prio) rd_val = {24'b0, prio_byte};
    end else if (is_prio) begin
      rd_val = prio_word;
    end else begin
      unique case (addr_i)
        A_GROUP:              rd_val = ns_lim ? '0 : grp_q;
        A_SETEN, A_CLREN:     rd_val = en_q & mask;
        A_SETPEND, A_CLRPEND: rd_val = (pend_q | {~edge_q & lvl_s, {NUM_SGI{1'b0}}}) & mask;
        A_SETACT, A_CLRACT:   rd_val = act_q & mask;
        A_CFG1:               rd_val = cfg1_rd;
        A_GMOD:               rd_val = sec_acc ? {16'b0, gmod_q} : '0;
        A_NSACC:              rd_val = sec_acc ? nsacc_q : '0;
        default:              rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q    <= '0;
      en_q     <= '0;
      pend_q   <= '0;
      act_q    <= '0;
      gmod_q   <= '0;
      nsacc_q  <= '0;
      edge_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      grp_q    <= grp_d;
      en_q     <= en_d;
      pend_q   <= pend_d;
      act_q    <= act_d;
      gmod_q   <= gmod_d;
      nsacc_q  <= nsacc_d;
      edge_q   <= edge_d;
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_val;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R12
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
  // R12
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);
  // R3
  grp_ns_wi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ns_i && !sec_dis_i && addr_i == A_GROUP) |=> $stable(grp_q));
  // R3
  gmod_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !byte_i && sec_dis_i && addr_i == A_GMOD) |=> rdata_o == '0);
  // R9
  cfg0_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i == A_CFG0) |=> rdata_o == '0);
endmodule

// File: tb/priv_irq_bank_tb.sv
`timescale 1ns/1ps
module priv_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_dis = 1'b0;
  logic        req = 1'b0, we = 1'b0, ns = 1'b0, byt = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [15:0] ppi = '0;
  logic        sreq = 1'b0;
  logic [3:0]  sid = '0;
  logic [1:0]  sgrp = '0;
  logic        sns = 1'b0;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  priv_irq_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sec_dis_i(sec_dis), .req_i(req), .we_i(we),
    .ns_i(ns), .byte_i(byt), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rvalid_o(rvalid), .ppi_lvl_i(ppi), .sgi_req_i(sreq), .sgi_id_i(sid),
    .sgi_grp_i(sgrp), .sgi_ns_i(sns)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check(rdata, 32'hx, "R12 unexpected rvalid");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic n, input logic b = 1'b0);
    @(negedge clk);
    req = 1; we = 1; ns = n; byt = b; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic n, input logic b,
                    input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    req = 1; we = 0; ns = n; byt = b; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic sgi(input logic [3:0] id, input logic [1:0] g, input logic n);
    @(negedge clk);
    sreq = 1; sid = id; sgrp = g; sns = n;
    @(negedge clk);
    sreq = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check({31'b0, rvalid}, 32'h0, "R1 rvalid after reset");
    rd(7'h00, 0, 0, 32'h0, "R1 group reset");
    rd(7'h04, 0, 0, 32'h0, "R1 enable reset");
    rd(7'h0C, 0, 0, 32'h0, "R1 pending reset");
    rd(7'h40, 0, 0, 32'h0, "R1 priority reset");
    rd(7'h30, 0, 0, 32'h0, "R12 unmapped read");

    // groups: 8..15 non-secure group 1
    wr(7'h00, 32'h0000FF00, 0);
    rd(7'h00, 0, 1, 32'h0, "R12 byte read outside priority");
    rd(7'h00, 0, 0, 32'h0000FF00, "R3 secure group read");
    wr(7'h00, 32'hFFFFFFFF, 1);
    rd(7'h00, 0, 0, 32'h0000FF00, "R3 ns group write ignored");
    rd(7'h00, 1, 0, 32'h0, "R3 ns group read zero");

    wr(7'h04, 32'hFFFFFFFF, 1);
    rd(7'h04, 0, 0, 32'h0000FF00, "R2 ns set-enable masked");
    wr(7'h04, 32'h00000003, 0);
    rd(7'h08, 1, 0, 32'h0000FF00, "R2 ns read masked");
    wr(7'h08, 32'h00000100, 0);
    rd(7'h04, 0, 0, 32'h0000FE03, "R4 clear-enable");
    wr(7'h08, 32'hFFFFFFFF, 1);
    rd(7'h04, 0, 0, 32'h00000003, "R2 ns clear masked");
    wr(7'h14, 32'h80000001, 0);
    rd(7'h18, 0, 0, 32'h80000001, "R4 set-active");
    wr(7'h18, 32'h00000001, 0);
    rd(7'h14, 0, 0, 32'h80000000, "R4 clear-active");

    // priorities
    wr(7'h40, 32'h44332211, 0);
    rd(7'h40, 0, 1, 32'h11, "R7 byte lane 0");
    rd(7'h43, 0, 1, 32'h44, "R7 byte lane 3");
    wr(7'h42, 32'h000000AB, 0, 1);
    rd(7'h40, 0, 0, 32'h44AB2211, "R7 byte write");
    wr(7'h48, 32'h00000040, 0);
    rd(7'h48, 1, 0, 32'h00000080, "R8 ns read shifted");
    wr(7'h49, 32'h00000020, 1, 1);
    rd(7'h49, 0, 1, 32'h90, "R8 ns write remapped");
    wr(7'h40, 32'h000000FF, 1, 1);
    rd(7'h40, 0, 0, 32'h44AB2211, "R2 ns priority write group0 ignored");
    rd(7'h40, 1, 0, 32'h0, "R8 ns read group0 zero");
    wr(7'h48, 32'h000000C1, 0, 1);
    rd(7'h48, 1, 1, 32'h82, "R8 ns read truncated");

    // trigger config
    wr(7'h1C, 32'hFFFFFFFF, 0);
    rd(7'h1C, 0, 0, 32'h0, "R9 first word ignored");
    wr(7'h20, 32'h0000000A, 0);
    rd(7'h20, 0, 0, 32'h0000000A, "R9 edge bits odd");
    wr(7'h20, 32'hAAAAAAAA, 1);
    rd(7'h20, 0, 0, 32'h0000000A, "R9 ns write masked");
    wr(7'h00, 32'h0010FF00, 0);
    wr(7'h20, 32'hAAAAAAAA, 1);
    rd(7'h20, 0, 0, 32'h0000020A, "R9 ns write allowed bit");
    rd(7'h20, 1, 0, 32'h00000200, "R9 ns read masked");

    // peripheral lines: 16,17,20 edge; 18 level
    ppi[0] = 1; idle(2);
    rd(7'h0C, 0, 0, 32'h00010000, "R6 edge latched");
    ppi[0] = 0; idle(2);
    rd(7'h0C, 0, 0, 32'h00010000, "R6 latch holds after drop");
    ppi[2] = 1; idle(2);
    rd(7'h0C, 0, 0, 32'h00050000, "R5 level shown");
    wr(7'h10, 32'h00040000, 0);
    rd(7'h0C, 0, 0, 32'h00050000, "R5 level survives clear");
    ppi[2] = 0; idle(2);
    rd(7'h0C, 0, 0, 32'h00010000, "R5 level gone");
    wr(7'h10, 32'h00010000, 0);
    rd(7'h10, 0, 0, 32'h0, "R4 clear-pending");
    ppi[1] = 1; idle(2);
    rd(7'h0C, 0, 0, 32'h00020000, "R6 second edge");
    wr(7'h10, 32'h00020000, 0);
    idle(3);
    rd(7'h0C, 0, 0, 32'h0, "R6 steady line no relatch");
    ppi[1] = 0;
    ppi[2] = 1; idle(2);
    ppi[2] = 0; idle(2);
    rd(7'h0C, 0, 0, 32'h0, "R6 level-trigger no latch");

    // software-generated: irq2 secure group 1
    wr(7'h24, 32'h00000004, 0);
    rd(7'h24, 0, 0, 32'h4, "R3 secure modifier read");
    rd(7'h24, 1, 0, 32'h0, "R3 ns modifier zero");
    wr(7'h24, 32'h000000FF, 1);
    rd(7'h24, 0, 0, 32'h4, "R3 ns modifier write ignored");
    sgi(4'd1, 2'd0, 0);
    sgi(4'd3, 2'd1, 0);
    sgi(4'd4, 2'd2, 0);
    sgi(4'd9, 2'd0, 0);
    sgi(4'd9, 2'd2, 0);
    sgi(4'd2, 2'd0, 0);
    sgi(4'd2, 2'd1, 0);
    rd(7'h0C, 0, 0, 32'h0000020E, "R10 group matching");
    wr(7'h10, 32'hFFFFFFFF, 0);
    sgi(4'd5, 2'd0, 1);
    sgi(4'd2, 2'd1, 1);
    sgi(4'd10, 2'd2, 1);
    rd(7'h0C, 0, 0, 32'h00000400, "R11 ns with no access");
    wr(7'h28, 32'h00002410, 0);
    sgi(4'd5, 2'd0, 1);
    sgi(4'd2, 2'd1, 1);
    sgi(4'd6, 2'd0, 1);
    rd(7'h0C, 0, 0, 32'h00000460, "R11 field 1 and 2");
    wr(7'h28, 32'h00002420, 0);
    sgi(4'd2, 2'd1, 1);
    rd(7'h0C, 0, 0, 32'h00000464, "R11 secure group 1 needs 2");
    rd(7'h28, 0, 0, 32'h00002420, "R3 access field read");

    // security disabled
    sec_dis = 1'b1;
    rd(7'h00, 1, 0, 32'h0010FF00, "R3 group visible when disabled");
    rd(7'h24, 0, 0, 32'h0, "R3 modifier zero when disabled");
    rd(7'h28, 0, 0, 32'h0, "R3 access zero when disabled");
    wr(7'h04, 32'h00010000, 1);
    rd(7'h04, 1, 0, 32'h00010003, "R2 no mask when disabled");
    rd(7'h48, 1, 1, 32'hC1, "R8 no remap when disabled");

    idle(3);
    check(exp_q.size(), 0, "R12 all reads returned");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule